// File: doc/BRIEF.md
# Packed Single-Precision Vector Move Unit

This unit carries out one packed single-precision move at a time between a 256-bit vector register file and a memory port. It receives an instruction that a front end has already split into fields: the opcode byte, the ModRM mode, reg and r/m fields, the register-extension bit, a flag that marks a VEX encoding, the VEX vector-length bit and the VEX extra-register field. It also receives the long-mode flag, the alignment-check controls, the current privilege level and the effective address. The unit reads the source, from a register or from memory. It writes the destination, to a register with per-lane write enables or to memory with byte enables. It can also report an invalid-opcode fault or an alignment-check fault.

Three encodings are supported. The legacy 128-bit form leaves the upper half of a destination register untouched. The VEX 128-bit form clears the upper half. The VEX 256-bit form moves the whole vector. A memory operand may sit at any byte address and never causes a general-protection fault. Alignment checking is the only misalignment fault, and a parameter enables it.

The unit takes a new instruction only while it is idle. Every instruction ends with a single-cycle done pulse.

Top module: `vecMoveUnit`

## Requirements
- R1: Opcode 8'h10 is the load direction. The register named by {long-mode AND rexR, modReg} is the destination. The source is register {0, modRm} when modMod is 2'b11, and memory otherwise.
- R2: Opcode 8'h11 is the store direction. The register named by {long-mode AND rexR, modReg} is the source. The destination is register {0, modRm} when modMod is 2'b11, and memory at effAddr otherwise.
- R3: A legacy (non-VEX) move into a register drives rfWrLaneEn = 2'b01. Bits 127:0 come from the source, and bits 255:128 of the destination keep their old value.
- R4: A VEX move with vexL = 0 into a register drives rfWrLaneEn = 2'b11, writes bits 127:0 from the source and writes zero to bits 255:128.
- R5: A VEX move with vexL = 1 copies all 256 bits, whether the destination is a register or memory.
- R6: A VEX encoding with vexVvvv other than 4'b1111 raises faultUd. So does any opcode byte other than 8'h10 or 8'h11. Such an instruction makes no register write and no memory request.
- R7: rexR becomes bit 3 of the reg-field register index only while longMode = 1. When longMode = 0, rexR is ignored.
- R8: A memory access asserts memReq until memRsp arrives, and keeps memAddr equal to effAddr, at any byte alignment. A 128-bit access sets memByteEn = 32'h0000FFFF and a 256-bit access sets all 32 bits. memWe is 1 only for a store.
- R9: With alignment checking enabled, a memory operand raises faultAc when all of these hold: cr0Am = 1, flagAc = 1, cpl = 3 and effAddr[2:0] != 0. That instruction makes no access. If faultUd also applies, faultUd wins and faultAc stays low. A register operand, or any of these conditions missing, raises no fault.
- R10: done rises for one cycle. For a register-to-register move it comes in the second cycle after acceptance. For a memory access it comes in the cycle after the memRsp cycle. For a fault it comes in the first cycle after acceptance, with the fault flag high in that same cycle only.
- R11: ready is high only while the unit is idle. instValid is ignored while ready is low.
- R12: After reset, ready = 1, and done, both fault flags, memReq and rfWrLaneEn are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction offered this cycle |
| opByte | input | 8 | Opcode byte following the 0F escape |
| modMod | input | 2 | ModRM mode field; 2'b11 means register operand |
| modReg | input | 3 | ModRM reg field |
| modRm | input | 3 | ModRM r/m field |
| rexR | input | 1 | Register-index extension bit |
| vexPresent | input | 1 | Instruction is VEX encoded |
| vexL | input | 1 | VEX vector length (1 = 256 bits) |
| vexVvvv | input | 4 | VEX extra register field |
| longMode | input | 1 | 64-bit mode active |
| cr0Am | input | 1 | Alignment-mask control bit |
| flagAc | input | 1 | Alignment-check flag |
| cpl | input | 2 | Current privilege level |
| effAddr | input | 64 | Effective address of a memory operand |
| ready | output | 1 | Unit idle, can accept |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| faultUd | output | 1 | Invalid-opcode fault, with done |
| faultAc | output | 1 | Alignment-check fault, with done |
| rfRdIdx | output | 4 | Register read index |
| rfRdData | input | 256 | Register read data (combinational) |
| rfWrIdx | output | 4 | Register write index |
| rfWrData | output | 256 | Register write data |
| rfWrLaneEn | output | 2 | Per-128-bit-lane write enable |
| memReq | output | 1 | Memory request, held until memRsp |
| memWe | output | 1 | Request is a write |
| memAddr | output | 64 | Byte address of the access |
| memByteEn | output | 32 | Byte enables of the access |
| memWdata | output | 256 | Write data |
| memRsp | input | 1 | Memory response, completes the request |
| memRdata | input | 256 | Read data, valid with memRsp |

## Verification
A wrong latched direction or index bit shows up at the ports as a write to the wrong register, or as a memory request whose memWe does not match the opcode. Both are visible in the first cycle after acceptance. A stale width or upper-lane flag appears at once as the wrong rfWrLaneEn or memByteEn pattern, or as non-zero upper write data. A control state that does not return to idle holds ready low and drops the done pulse, so the latency measured for that same instruction is wrong. A fault flag that was not cleared stays high in the cycle after done.

// File: rtl/vmov_pkg.sv
package vmov_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MOVE,
    ST_MEM,
    ST_FIN
  } vmovState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic rfWrite;
    logic fromMem;
    logic wide;
    logic zeroUpper;
    logic memReq;
    logic memWrite;
  } vmovStrobe_t;

  localparam logic [7:0] OP_LOAD  = 8'h10;
  localparam logic [7:0] OP_STORE = 8'h11;
  localparam logic [3:0] VVVV_OK  = 4'b1111;
  localparam logic [1:0] MOD_REG  = 2'b11;
  localparam logic [1:0] CPL_USER = 2'd3;

endpackage

// File: rtl/vmovCtrl.sv
module vmovCtrl
  import vmov_pkg::*;
#(
  parameter bit ALIGN_CHECK = 1'b1,
  parameter int AC_LSB      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [7:0]        opByte,
  input  logic [1:0]        modMod,
  input  logic              vexPresent,
  input  logic              vexL,
  input  logic [3:0]        vexVvvv,
  input  logic              cr0Am,
  input  logic              flagAc,
  input  logic [1:0]        cpl,
  input  logic [AC_LSB-1:0] addrLow,
  input  logic              memRsp,
  output logic              ready,
  output logic              done,
  output logic              faultUd,
  output logic              faultAc,
  output vmovStrobe_t       strobe
);

  vmovState_e state, stateNext;

  logic storeQ, wideQ, zeroUpperQ, udQ, acQ;

  // decode of the offered instruction
  logic opKnown, vexBad, udHit, memOperand, misAligned, acHit, accept;

  always_comb begin
    opKnown    = (opByte == OP_LOAD) || (opByte == OP_STORE);
    vexBad     = vexPresent && (vexVvvv != VVVV_OK);
    udHit      = !opKnown || vexBad;
    memOperand = (modMod != MOD_REG);
    misAligned = |addrLow;
    acHit      = ALIGN_CHECK && cr0Am && flagAc && (cpl == CPL_USER)
                 && memOperand && misAligned && !udHit;
    accept     = (state == ST_IDLE) && instValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (udHit || acHit)   stateNext = ST_FIN;
        else if (memOperand)  stateNext = ST_MEM;
        else                  stateNext = ST_MOVE;
      end
      ST_MOVE: stateNext = ST_FIN;
      ST_MEM:  if (memRsp) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      storeQ     <= 1'b0;
      wideQ      <= 1'b0;
      zeroUpperQ <= 1'b0;
      udQ        <= 1'b0;
      acQ        <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        storeQ     <= (opByte == OP_STORE);
        wideQ      <= vexPresent && vexL;
        zeroUpperQ <= vexPresent && !vexL;
        udQ        <= udHit;
        acQ        <= acHit;
      end else if (state == ST_FIN) begin
        udQ <= 1'b0;
        acQ <= 1'b0;
      end
    end
  end

  always_comb begin
    ready   = (state == ST_IDLE);
    done    = (state == ST_FIN);
    faultUd = (state == ST_FIN) && udQ;
    faultAc = (state == ST_FIN) && acQ;

    strobe.capture   = accept;
    strobe.wide      = wideQ;
    strobe.zeroUpper = zeroUpperQ;
    strobe.memReq    = (state == ST_MEM);
    strobe.memWrite  = storeQ;
    strobe.fromMem   = (state == ST_MEM) && !storeQ;
    strobe.rfWrite   = (state == ST_MOVE) || ((state == ST_MEM) && memRsp && !storeQ);
  end

endmodule

// File: rtl/vmovDatapath.sv
module vmovDatapath
  import vmov_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 128,
  parameter int ADDR_W = 64,
  parameter int NREG   = 16,
  localparam int LANES  = VEC_W / LANE_W,
  localparam int IDX_W  = $clog2(NREG),
  localparam int BYTES  = VEC_W / 8,
  localparam int LANE_B = LANE_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  vmovStrobe_t       strobe,
  input  logic              storeDir,
  input  logic [1:0]        modMod,
  input  logic [2:0]        modReg,
  input  logic [2:0]        modRm,
  input  logic              rexR,
  input  logic              longMode,
  input  logic [ADDR_W-1:0] effAddr,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [VEC_W-1:0]  rfRdData,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [VEC_W-1:0]  rfWrData,
  output logic [LANES-1:0]  rfWrLaneEn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTES-1:0]  memByteEn,
  output logic [VEC_W-1:0]  memWdata,
  input  logic [VEC_W-1:0]  memRdata
);

  logic [IDX_W-1:0]  regIdx, rmIdx, srcQ, dstQ;
  logic [ADDR_W-1:0] addrQ;
  logic              regForm;

  assign regIdx  = IDX_W'({longMode & rexR, modReg});
  assign rmIdx   = IDX_W'({1'b0, modRm});
  assign regForm = (modMod == MOD_REG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ  <= '0;
      dstQ  <= '0;
      addrQ <= '0;
    end else if (strobe.capture) begin
      // store direction reads reg, writes r/m; load direction the reverse
      srcQ  <= storeDir ? regIdx : rmIdx;
      dstQ  <= (storeDir && regForm) ? rmIdx : regIdx;
      addrQ <= effAddr;
    end
  end

  assign rfRdIdx = srcQ;
  assign rfWrIdx = dstQ;
  assign memReq  = strobe.memReq;
  assign memWe   = strobe.memReq && strobe.memWrite;
  assign memAddr = addrQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam bit LOW_LANE = (g == 0);
    logic [LANE_W-1:0] srcLane;
    logic              laneLive;

    assign laneLive = LOW_LANE || strobe.wide;
    assign srcLane  = strobe.fromMem ? memRdata[g*LANE_W +: LANE_W]
                                     : rfRdData[g*LANE_W +: LANE_W];
    assign rfWrData[g*LANE_W +: LANE_W] = laneLive ? srcLane : '0;
    assign rfWrLaneEn[g] = strobe.rfWrite && (laneLive || strobe.zeroUpper);
    assign memWdata[g*LANE_W +: LANE_W] = laneLive ? rfRdData[g*LANE_W +: LANE_W] : '0;
    assign memByteEn[g*LANE_B +: LANE_B] = {LANE_B{strobe.memReq && laneLive}};
  end

endmodule

// File: rtl/vecMoveUnit.sv
module vecMoveUnit
  import vmov_pkg::*;
#(
  parameter int VEC_W       = 256,
  parameter int LANE_W      = 128,
  parameter int ADDR_W      = 64,
  parameter int NREG        = 16,
  parameter bit ALIGN_CHECK = 1'b1,
  parameter int AC_ALIGN    = 8,
  localparam int LANES  = VEC_W / LANE_W,
  localparam int IDX_W  = $clog2(NREG),
  localparam int BYTES  = VEC_W / 8,
  localparam int AC_LSB = $clog2(AC_ALIGN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [7:0]        opByte,
  input  logic [1:0]        modMod,
  input  logic [2:0]        modReg,
  input  logic [2:0]        modRm,
  input  logic              rexR,
  input  logic              vexPresent,
  input  logic              vexL,
  input  logic [3:0]        vexVvvv,
  input  logic              longMode,
  input  logic              cr0Am,
  input  logic              flagAc,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] effAddr,
  output logic              ready,
  output logic              done,
  output logic              faultUd,
  output logic              faultAc,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [VEC_W-1:0]  rfRdData,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [VEC_W-1:0]  rfWrData,
  output logic [LANES-1:0]  rfWrLaneEn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTES-1:0]  memByteEn,
  output logic [VEC_W-1:0]  memWdata,
  input  logic              memRsp,
  input  logic [VEC_W-1:0]  memRdata
);

  vmovStrobe_t strobe;

  vmovCtrl #(
    .ALIGN_CHECK(ALIGN_CHECK),
    .AC_LSB     (AC_LSB)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .opByte    (opByte),
    .modMod    (modMod),
    .vexPresent(vexPresent),
    .vexL      (vexL),
    .vexVvvv   (vexVvvv),
    .cr0Am     (cr0Am),
    .flagAc    (flagAc),
    .cpl       (cpl),
    .addrLow   (effAddr[AC_LSB-1:0]),
    .memRsp    (memRsp),
    .ready     (ready),
    .done      (done),
    .faultUd   (faultUd),
    .faultAc   (faultAc),
    .strobe    (strobe)
  );

  vmovDatapath #(
    .VEC_W (VEC_W),
    .LANE_W(LANE_W),
    .ADDR_W(ADDR_W),
    .NREG  (NREG)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .storeDir  (opByte == OP_STORE),
    .modMod    (modMod),
    .modReg    (modReg),
    .modRm     (modRm),
    .rexR      (rexR),
    .longMode  (longMode),
    .effAddr   (effAddr),
    .rfRdIdx   (rfRdIdx),
    .rfRdData  (rfRdData),
    .rfWrIdx   (rfWrIdx),
    .rfWrData  (rfWrData),
    .rfWrLaneEn(rfWrLaneEn),
    .memReq    (memReq),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memByteEn (memByteEn),
    .memWdata  (memWdata),
    .memRdata  (memRdata)
  );

endmodule

// File: rtl/vmovChecker.sv
module vmovChecker #(
  parameter int LANES  = 2,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              done,
  input logic              faultUd,
  input logic              faultAc,
  input logic [LANES-1:0]  rfWrLaneEn,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRsp
);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (!memReq && rfWrLaneEn == '0 && !done));

  assert_done_then_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ready);

  assert_fault_with_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (faultUd || faultAc) |-> done);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_rsp_to_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memRsp) |=> done);

  assert_fault_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(faultUd && faultAc));

  assert_fault_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultUd |-> (!memReq && rfWrLaneEn == '0));

  assert_low_lane_written_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrLaneEn != '0) |-> rfWrLaneEn[0]);

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRsp) |=> (memReq && $stable(memAddr) && $stable(memWe)));

endmodule

bind vecMoveUnit vmovChecker #(
  .LANES (LANES),
  .ADDR_W(ADDR_W)
) i_vmovChecker (
  .clk       (clk),
  .rstN      (rstN),
  .ready     (ready),
  .done      (done),
  .faultUd   (faultUd),
  .faultAc   (faultAc),
  .rfWrLaneEn(rfWrLaneEn),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .memRsp    (memRsp)
);

// File: tb/test_vecMoveUnit.sv
module test_vecMoveUnit;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ADDR_BASE = 64'h0000_7F00_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         instValid = 1'b0;
  logic [7:0]   opByte = 8'h10;
  logic [1:0]   modMod = 2'b11;
  logic [2:0]   modReg = 3'd0;
  logic [2:0]   modRm = 3'd0;
  logic         rexR = 1'b0;
  logic         vexPresent = 1'b0;
  logic         vexL = 1'b0;
  logic [3:0]   vexVvvv = 4'hF;
  logic         longMode = 1'b0;
  logic         cr0Am = 1'b0;
  logic         flagAc = 1'b0;
  logic [1:0]   cpl = 2'd0;
  logic [63:0]  effAddr = '0;
  logic         ready, done, faultUd, faultAc;
  logic [3:0]   rfRdIdx, rfWrIdx;
  logic [255:0] rfRdData, rfWrData, memWdata, memRdata;
  logic [1:0]   rfWrLaneEn;
  logic         memReq, memWe;
  logic [63:0]  memAddr;
  logic [31:0]  memByteEn;
  logic         memRsp;

  vecMoveUnit i_vecMoveUnit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opByte(opByte),
    .modMod(modMod), .modReg(modReg), .modRm(modRm), .rexR(rexR),
    .vexPresent(vexPresent), .vexL(vexL), .vexVvvv(vexVvvv),
    .longMode(longMode), .cr0Am(cr0Am), .flagAc(flagAc), .cpl(cpl),
    .effAddr(effAddr), .ready(ready), .done(done), .faultUd(faultUd),
    .faultAc(faultAc), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
    .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .rfWrLaneEn(rfWrLaneEn),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWdata(memWdata), .memRsp(memRsp),
    .memRdata(memRdata)
  );

  // environment: register file, memory, responder, activity monitor
  logic [255:0] rf [16];
  logic [7:0]   memB [256];
  logic [255:0] refRf [16];
  logic [7:0]   refMem [256];
  int           memLat = 0;
  int           rspCnt = 0;
  int           activity = 0;
  logic [63:0]  lastAddr = '0;
  logic [31:0]  lastBe = '0;
  logic         lastWe = 1'b0;

  assign rfRdData = rf[rfRdIdx];

  always_comb begin
    for (int i = 0; i < 32; i++) memRdata[i*8 +: 8] = memB[8'(memAddr[7:0] + 8'(i))];
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < 16; r++)
        for (int w = 0; w < 8; w++) rf[r][w*32 +: 32] <= {8'(r), 8'(w), 16'hC3A5};
      for (int j = 0; j < 256; j++) memB[j] <= 8'(j) ^ 8'h5A;
      memRsp <= 1'b0;
      rspCnt <= 0;
    end else begin
      for (int l = 0; l < 2; l++)
        if (rfWrLaneEn[l]) rf[rfWrIdx][l*128 +: 128] <= rfWrData[l*128 +: 128];
      if (memReq && memRsp && memWe)
        for (int i = 0; i < 32; i++)
          if (memByteEn[i]) memB[8'(memAddr[7:0] + 8'(i))] <= memWdata[i*8 +: 8];
      if (memRsp) begin
        memRsp <= 1'b0;
        rspCnt <= 0;
      end else if (memReq) begin
        if (rspCnt >= memLat) memRsp <= 1'b1;
        else rspCnt <= rspCnt + 1;
      end
    end
    if (rstN && (rfWrLaneEn != '0 || memReq)) activity <= activity + 1;
    if (memReq) begin
      lastAddr <= memAddr;
      lastBe   <= memByteEn;
      lastWe   <= memWe;
    end
  end

  int  tests = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [255:0] refRead(input logic [7:0] a);
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = refMem[8'(a + 8'(i))];
    return v;
  endfunction

  function automatic logic [255:0] mergeReg(input logic [255:0] old, input logic [255:0] src,
                                            input logic vx, input logic vl);
    if (vx && vl) return src;
    if (vx)       return {128'h0, src[127:0]};
    return {old[255:128], src[127:0]};
  endfunction

  task automatic runInst(input string tag, input logic [7:0] op, input logic [1:0] md,
                         input logic [2:0] rg, input logic [2:0] rm, input logic rx,
                         input logic vx, input logic vl, input logic [3:0] vv,
                         input logic lm, input logic am, input logic acb,
                         input logic [1:0] pl, input logic [7:0] addr,
                         input int lat, input bit poke);
    bit ud, acf, isMem, fault;
    logic [3:0] regI, rmI;
    logic [255:0] srcVal;
    int wBytes, expLat, n, actStart, bad;
    ud     = !(op == 8'h10 || op == 8'h11) || (vx && vv != 4'hF);
    isMem  = (md != 2'b11);
    acf    = !ud && am && acb && (pl == 2'd3) && isMem && (addr[2:0] != 3'd0);
    fault  = ud || acf;
    regI   = {lm & rx, rg};
    rmI    = {1'b0, rm};
    wBytes = (vx && vl) ? 32 : 16;
    expLat = fault ? 1 : (isMem ? lat + 3 : 2);
    if (!fault) begin
      if (op == 8'h10) begin
        srcVal = isMem ? refRead(addr) : refRf[rmI];
        refRf[regI] = mergeReg(refRf[regI], srcVal, vx, vl);
      end else begin
        srcVal = refRf[regI];
        if (isMem) begin
          for (int i = 0; i < wBytes; i++) refMem[8'(addr + 8'(i))] = srcVal[i*8 +: 8];
        end else begin
          refRf[rmI] = mergeReg(refRf[rmI], srcVal, vx, vl);
        end
      end
    end

    @(negedge clk);
    check("R11", "ready before issue", {255'h0, ready}, 256'h1);
    opByte = op; modMod = md; modReg = rg; modRm = rm; rexR = rx;
    vexPresent = vx; vexL = vl; vexVvvv = vv; longMode = lm;
    cr0Am = am; flagAc = acb; cpl = pl; effAddr = ADDR_BASE | 64'(addr);
    memLat = lat;
    actStart = activity;
    instValid = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        if (poke) begin
          check("R11", "ready while busy", {255'h0, ready}, 256'h0);
          opByte = 8'h00; vexPresent = 1'b0;
        end else instValid = 1'b0;
      end else if (n == 2) instValid = 1'b0;
    end while (!done && n < 60);

    check(tag, "R10 latency", 256'(n), 256'(expLat));
    check(tag, "R6 faultUd", {255'h0, faultUd}, {255'h0, ud});
    check(tag, "R9 faultAc", {255'h0, faultAc}, {255'h0, acf});
    @(negedge clk);
    check(tag, "R10 done single pulse", {253'h0, done, faultUd, faultAc}, 256'h0);
    if (fault)
      check(tag, "R6 no write on fault", 256'(activity - actStart), 256'h0);
    if (isMem && !fault) begin
      check(tag, "R8 address", {192'h0, lastAddr}, {192'h0, ADDR_BASE | 64'(addr)});
      check(tag, "R8 byte enables", {224'h0, lastBe},
            {224'h0, (wBytes == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF});
      check(tag, "R8 write flag", {255'h0, lastWe}, {255'h0, (op == 8'h11)});
    end
    bad = 0;
    for (int r = 0; r < 16; r++) if (rf[r] !== refRf[r]) bad++;
    check(tag, "register file mismatches", 256'(bad), 256'h0);
    bad = 0;
    for (int j = 0; j < 256; j++) if (memB[j] !== refMem[j]) bad++;
    check(tag, "memory mismatches", 256'(bad), 256'h0);
  endtask

  // per-clock reference of the idle outputs
  bit expectIdle = 1'b0;
  always @(negedge clk) begin
    if (expectIdle && rstN && !instValid && ready) begin
      if (memReq || rfWrLaneEn != '0 || done) begin
        fails++; tests++;
        $display("FAIL R11 idle outputs active actual=%0b%0b%0b expected=000",
                 memReq, |rfWrLaneEn, done);
      end
    end
  end

  initial begin
    for (int r = 0; r < 16; r++)
      for (int w = 0; w < 8; w++) refRf[r][w*32 +: 32] = {8'(r), 8'(w), 16'hC3A5};
    for (int j = 0; j < 256; j++) refMem[j] = 8'(j) ^ 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R12", "reset outputs",
          {250'h0, ready, done, faultUd, faultAc, memReq, |rfWrLaneEn}, 256'b100000);
    expectIdle = 1'b1;

    //        tag    op     md     rg  rm  rx  vx  vl  vvvv lm  am  ac  pl  addr  lat poke
    runInst("R1",  8'h10, 2'b11, 3'd2, 3'd5, 0, 0, 0, 4'hF, 0, 0, 0, 2'd0, 8'h00, 0, 0); // R3 upper kept
    runInst("R4",  8'h10, 2'b11, 3'd3, 3'd6, 0, 1, 0, 4'hF, 0, 0, 0, 2'd0, 8'h00, 0, 0);
    runInst("R5",  8'h10, 2'b11, 3'd4, 3'd1, 0, 1, 1, 4'hF, 0, 0, 0, 2'd0, 8'h00, 0, 0);
    runInst("R2",  8'h11, 2'b11, 3'd0, 3'd7, 0, 0, 0, 4'hF, 0, 0, 0, 2'd0, 8'h00, 0, 0);
    runInst("R4",  8'h11, 2'b11, 3'd5, 3'd2, 0, 1, 0, 4'hF, 0, 0, 0, 2'd0, 8'h00, 0, 0);
    runInst("R7",  8'h10, 2'b11, 3'd1, 3'd2, 1, 1, 1, 4'hF, 1, 0, 0, 2'd0, 8'h00, 0, 0);
    runInst("R7",  8'h10, 2'b11, 3'd1, 3'd3, 1, 0, 0, 4'hF, 0, 0, 0, 2'd0, 8'h00, 0, 0);
    runInst("R8",  8'h10, 2'b00, 3'd6, 3'd0, 0, 0, 0, 4'hF, 0, 0, 0, 2'd3, 8'h13, 2, 0); // R1 load
    runInst("R8",  8'h11, 2'b10, 3'd1, 3'd0, 1, 1, 1, 4'hF, 1, 0, 0, 2'd0, 8'h45, 0, 0); // R5 store
    runInst("R8",  8'h11, 2'b01, 3'd6, 3'd0, 0, 0, 0, 4'hF, 0, 0, 0, 2'd0, 8'h80, 1, 0); // R2 store
    runInst("R4",  8'h10, 2'b00, 3'd7, 3'd0, 0, 1, 0, 4'hF, 0, 0, 0, 2'd0, 8'h21, 1, 0);
    runInst("R5",  8'h10, 2'b00, 3'd2, 3'd0, 0, 1, 1, 4'hF, 0, 0, 0, 2'd0, 8'hF3, 0, 0);
    runInst("R6",  8'h10, 2'b00, 3'd3, 3'd0, 0, 1, 0, 4'h7, 0, 0, 0, 2'd0, 8'h10, 0, 0);
    runInst("R6",  8'h28, 2'b11, 3'd3, 3'd4, 0, 0, 0, 4'hF, 0, 0, 0, 2'd0, 8'h00, 0, 0);
    runInst("R6",  8'h11, 2'b00, 3'd4, 3'd0, 0, 1, 1, 4'h0, 0, 0, 0, 2'd0, 8'h40, 0, 0);
    runInst("R9",  8'h10, 2'b00, 3'd5, 3'd0, 0, 0, 0, 4'hF, 0, 1, 1, 2'd3, 8'h33, 0, 0);
    runInst("R9",  8'h11, 2'b00, 3'd5, 3'd0, 0, 0, 0, 4'hF, 0, 1, 1, 2'd3, 8'h34, 0, 0);
    runInst("R9",  8'h10, 2'b00, 3'd5, 3'd0, 0, 0, 0, 4'hF, 0, 1, 1, 2'd3, 8'h38, 1, 0);
    runInst("R9",  8'h10, 2'b00, 3'd0, 3'd0, 0, 0, 0, 4'hF, 0, 1, 1, 2'd0, 8'h3B, 0, 0);
    runInst("R9",  8'h10, 2'b00, 3'd0, 3'd0, 0, 1, 0, 4'h3, 0, 1, 1, 2'd3, 8'h3B, 0, 0);
    runInst("R9",  8'h10, 2'b11, 3'd6, 3'd1, 0, 0, 0, 4'hF, 0, 1, 1, 2'd3, 8'h3B, 0, 0);
    runInst("R11", 8'h10, 2'b00, 3'd4, 3'd0, 0, 1, 1, 4'hF, 0, 0, 0, 2'd0, 8'h61, 3, 1);
    runInst("R10", 8'h11, 2'b00, 3'd4, 3'd0, 0, 0, 0, 4'hF, 0, 0, 0, 2'd0, 8'hFA, 4, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule